// File: doc/BRIEF.md
# Word-Group Select and Cycle Sequencer

This block runs a single fixed-length access cycle of a word-organized memory that holds 16,384 words of 9 bits. The array is treated as 1024 word lines. Each word line is crossed by 16 wire positions in each of 9 bit channels. When the block is idle it takes a request together with an address and a read/write flag. It captures both, lowers its ready flag and runs a timed sequence from a cycle counter. Once the sequence ends it raises ready again.

The captured address is split into three select groups. A 4-bit wire index drives a one-hot 1-of-16 wire select, and the same index applies to every bit channel. A 6-bit word-group index is decoded as two 1-of-8 halves, a base group and an emitter group. The active word-group line is the one where the active base output and the active emitter output cross. A 4-bit index drives a one-hot 1-of-16 line select on the other side of the word-line matrix. The sequencer turns on the noisy switches first, in the order wire, word-group, line. Only after that does it release the current sink that absorbs the word current while idle, so the current is steered into the chosen word line. Sensing then takes place in a quiet window. On a read the restorer clamp is released just ahead of a short strobe, and a data-valid pulse follows the strobe. On a write a complement phase runs first and the true-data phase follows it. All timing points are parameters counted in clocks.

Top module: `wsel_cycle_seq`

## Requirements
- R1: After reset, and at all times when idle, ready_o is 1, sink_en_o is 1 and rest_hold_o is 1. All select enables, word_gate_o, strobe_o, rd_valid_o, wph1_o and wph2_o are 0.
- R2: A request is accepted at a clock edge where req_i=1 and ready_o=1. In the next clock the cycle count is 0. w_sel_o is one-hot, with bit addr_i[3:0] set, for counts 2 through 43, and is all zero otherwise.
- R3: The word-group index is addr_i[9:4]. b_base_o has bit addr_i[6:4] set and b_emit_o has bit addr_i[9:7] set, so the active line is emit*8+base. Both are one-hot for counts 6 through 43 and all zero otherwise.
- R4: a_sel_o has bit addr_i[13:10] set for counts 10 through 43 and is all zero otherwise. Every select uses the address captured at acceptance and stays unchanged for the whole cycle.
- R5: word_gate_o is 1 and sink_en_o is 0 for counts 12 through 39 only. This lies inside the span where all three select groups are on.
- R6: The turn-on order in a cycle is wire select, then word-group select, then line select, then word current. No select group rises while the group before it in this order is off.
- R7: On a read (wr_i=0), rest_hold_o is 0 for counts 26 through 29 and strobe_o is 1 for counts 28 and 29. rd_valid_o pulses for one clock at count 30.
- R8: On a write (wr_i=1), wph1_o (complement phase) is 1 for counts 14 through 21 and wph2_o (true phase) is 1 for counts 22 through 29. A write raises no strobe, no data-valid pulse and no restorer release.
- R9: A cycle lasts 50 clocks, counts 0 through 49. The word current and all selects are off before ready_o returns to 1 at the clock after count 49.
- R10: A request raised while ready_o=0 is neither accepted nor remembered. The running cycle and its selects are unchanged. If req_i is low again when the cycle ends, no new cycle starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Cycle request, sampled while ready |
| wr_i | input | 1 | 1 = write cycle, 0 = read cycle |
| addr_i | input | 14 | Word address: [3:0] wire, [6:4] base group, [9:7] emitter group, [13:10] line |
| ready_o | output | 1 | 1 when idle and able to accept a request |
| rd_valid_o | output | 1 | One-clock read data-valid pulse |
| w_sel_o | output | 16 | One-hot wire select shared by all bit channels |
| b_base_o | output | 8 | One-hot word-group base-half select |
| b_emit_o | output | 8 | One-hot word-group emitter-half select |
| a_sel_o | output | 16 | One-hot line select |
| sink_en_o | output | 1 | Word-current sink enable, high in standby |
| word_gate_o | output | 1 | Word-current drive gate |
| rest_hold_o | output | 1 | Restorer clamp, low while released for sensing |
| strobe_o | output | 1 | Sense strobe window |
| wph1_o | output | 1 | Write complement phase |
| wph2_o | output | 1 | Write true-data phase |

## Verification
Reads and writes are run at all-zero and all-one addresses, at alternating-bit addresses and at addresses where only one field is non-zero. The alternating and single-field patterns show a swap between the base and emitter halves, or a shift of one field into the next. A full vector of timing outputs is compared at every clock of each cycle. Running the same address as a read and then as a write separates the strobe and restorer path from the two write phases. A second request with a different address and opposite direction is raised in the middle of a cycle. This shows whether a busy request disturbs the running selects or starts a cycle of its own.

// File: rtl/wsel_pkg.sv
package wsel_pkg;

   // Timing windows produced by the cycle timer for one clock.
   typedef struct packed {
      logic w_win;
      logic b_win;
      logic a_win;
      logic cur_win;
      logic rel_win;
      logic strb;
      logic valid;
      logic ph1;
      logic ph2;
   } wsel_phase_t;

   // Half-open window test on cycle counts.
   function automatic logic in_win(input int unsigned c,
                                   input int unsigned lo,
                                   input int unsigned hi);
      return (c >= lo) && (c < hi);
   endfunction

endpackage

// File: rtl/wsel_onehot_dec.sv
module wsel_onehot_dec #(
   parameter int unsigned IDX_W = 4
) (
   input  logic                 en_i,
   input  logic [IDX_W-1:0]     idx_i,
   output logic [(1<<IDX_W)-1:0] oh_o
);
   localparam int unsigned N_OUT = 1 << IDX_W;

   if (IDX_W < 1 || IDX_W > 8) begin : g_bad_w
      $error("wsel_onehot_dec: IDX_W out of range");
   end

   for (genvar i = 0; i < N_OUT; i++) begin : g_out
      assign oh_o[i] = en_i && (idx_i == IDX_W'(i));
   end
endmodule

// File: rtl/wsel_req_latch.sv
module wsel_req_latch #(
   parameter int unsigned W_BITS  = 4,
   parameter int unsigned BH_BITS = 3,
   parameter int unsigned A_BITS  = 4,
   localparam int unsigned ADDR_W = W_BITS + 2*BH_BITS + A_BITS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic               wr_i,
   input  logic [ADDR_W-1:0]  addr_i,
   output logic               rd_o,
   output logic [W_BITS-1:0]  w_idx_o,
   output logic [BH_BITS-1:0] bb_idx_o,
   output logic [BH_BITS-1:0] be_idx_o,
   output logic [A_BITS-1:0]  a_idx_o
);
   localparam int unsigned BB_LO = W_BITS;
   localparam int unsigned BE_LO = W_BITS + BH_BITS;
   localparam int unsigned A_LO  = W_BITS + 2*BH_BITS;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_o     <= 1'b1;
         w_idx_o  <= '0;
         bb_idx_o <= '0;
         be_idx_o <= '0;
         a_idx_o  <= '0;
      end else if (load_i) begin
         rd_o     <= !wr_i;
         w_idx_o  <= addr_i[W_BITS-1:0];
         bb_idx_o <= addr_i[BB_LO +: BH_BITS];
         be_idx_o <= addr_i[BE_LO +: BH_BITS];
         a_idx_o  <= addr_i[A_LO +: A_BITS];
      end
   end
endmodule

// File: rtl/wsel_timer.sv
module wsel_timer
   import wsel_pkg::*;
#(
   parameter int unsigned CYC_LEN   = 50,
   parameter int unsigned T_W_ON    = 2,
   parameter int unsigned T_B_ON    = 6,
   parameter int unsigned T_A_ON    = 10,
   parameter int unsigned T_CUR_ON  = 12,
   parameter int unsigned T_PH1     = 14,
   parameter int unsigned T_PH2     = 22,
   parameter int unsigned T_PH_END  = 30,
   parameter int unsigned T_REL     = 26,
   parameter int unsigned T_STRB    = 28,
   parameter int unsigned STRB_LEN  = 2,
   parameter int unsigned T_VALID   = 30,
   parameter int unsigned T_CUR_OFF = 40,
   parameter int unsigned T_SEL_OFF = 44,
   localparam int unsigned CNT_W    = $clog2(CYC_LEN)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        rd_i,
   output logic        active_o,
   output wsel_phase_t ph_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_LEN - 1);
   localparam int unsigned T_STRB_END = T_STRB + STRB_LEN;

   logic [CNT_W-1:0] cnt;
   logic             active;
   int unsigned      c;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (!active) begin
         active <= start_i;
         cnt    <= '0;
      end else if (cnt == LAST) begin
         active <= 1'b0;
         cnt    <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign active_o = active;
   assign c = 32'(cnt);

   always_comb begin
      ph_o         = '0;
      ph_o.w_win   = active && in_win(c, T_W_ON, T_SEL_OFF);
      ph_o.b_win   = active && in_win(c, T_B_ON, T_SEL_OFF);
      ph_o.a_win   = active && in_win(c, T_A_ON, T_SEL_OFF);
      ph_o.cur_win = active && in_win(c, T_CUR_ON, T_CUR_OFF);
      ph_o.rel_win = active && rd_i && in_win(c, T_REL, T_STRB_END);
      ph_o.strb    = active && rd_i && in_win(c, T_STRB, T_STRB_END);
      ph_o.valid   = active && rd_i && (c == T_VALID);
      ph_o.ph1     = active && !rd_i && in_win(c, T_PH1, T_PH2);
      ph_o.ph2     = active && !rd_i && in_win(c, T_PH2, T_PH_END);
   end
endmodule

// File: rtl/wsel_cycle_seq.sv
module wsel_cycle_seq
   import wsel_pkg::*;
#(
   parameter int unsigned W_BITS    = 4,
   parameter int unsigned BH_BITS   = 3,
   parameter int unsigned A_BITS    = 4,
   parameter int unsigned CYC_LEN   = 50,
   parameter int unsigned T_W_ON    = 2,
   parameter int unsigned T_B_ON    = 6,
   parameter int unsigned T_A_ON    = 10,
   parameter int unsigned T_CUR_ON  = 12,
   parameter int unsigned T_PH1     = 14,
   parameter int unsigned T_PH2     = 22,
   parameter int unsigned T_PH_END  = 30,
   parameter int unsigned T_REL     = 26,
   parameter int unsigned T_STRB    = 28,
   parameter int unsigned STRB_LEN  = 2,
   parameter int unsigned T_VALID   = 30,
   parameter int unsigned T_CUR_OFF = 40,
   parameter int unsigned T_SEL_OFF = 44,
   localparam int unsigned ADDR_W   = W_BITS + 2*BH_BITS + A_BITS,
   localparam int unsigned W_N      = 1 << W_BITS,
   localparam int unsigned BH_N     = 1 << BH_BITS,
   localparam int unsigned A_N      = 1 << A_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              ready_o,
   output logic              rd_valid_o,
   output logic [W_N-1:0]    w_sel_o,
   output logic [BH_N-1:0]   b_base_o,
   output logic [BH_N-1:0]   b_emit_o,
   output logic [A_N-1:0]    a_sel_o,
   output logic              sink_en_o,
   output logic              word_gate_o,
   output logic              rest_hold_o,
   output logic              strobe_o,
   output logic              wph1_o,
   output logic              wph2_o
);
   // Elaboration-time checks on the timing plan
   if (!(T_W_ON < T_B_ON && T_B_ON < T_A_ON && T_A_ON < T_CUR_ON)) begin : g_bad_order
      $error("wsel_cycle_seq: select turn-on points must be strictly ordered");
   end
   if (!(T_CUR_ON < T_REL && T_REL < T_STRB && STRB_LEN > 0)) begin : g_bad_sense
      $error("wsel_cycle_seq: restorer release must precede strobe after current on");
   end
   if (!(T_VALID >= T_STRB + STRB_LEN && T_VALID < T_CUR_OFF)) begin : g_bad_valid
      $error("wsel_cycle_seq: data-valid point outside sensing span");
   end
   if (!(T_CUR_ON <= T_PH1 && T_PH1 < T_PH2 && T_PH2 < T_PH_END && T_PH_END <= T_CUR_OFF))
   begin : g_bad_write
      $error("wsel_cycle_seq: write phases must lie inside the current window");
   end
   if (!(T_CUR_OFF <= T_SEL_OFF && T_SEL_OFF < CYC_LEN)) begin : g_bad_tail
      $error("wsel_cycle_seq: teardown must finish before the cycle ends");
   end
   if (W_BITS < 1 || BH_BITS < 1 || A_BITS < 1) begin : g_bad_split
      $error("wsel_cycle_seq: every select group needs at least one bit");
   end

   logic               active;
   logic               load;
   logic               cyc_rd;
   logic [W_BITS-1:0]  w_idx;
   logic [BH_BITS-1:0] bb_idx;
   logic [BH_BITS-1:0] be_idx;
   logic [A_BITS-1:0]  a_idx;
   wsel_phase_t        ph;

   assign load = req_i && !active;

   wsel_req_latch #(
      .W_BITS (W_BITS),
      .BH_BITS(BH_BITS),
      .A_BITS (A_BITS)
   ) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .wr_i    (wr_i),
      .addr_i  (addr_i),
      .rd_o    (cyc_rd),
      .w_idx_o (w_idx),
      .bb_idx_o(bb_idx),
      .be_idx_o(be_idx),
      .a_idx_o (a_idx)
   );

   wsel_timer #(
      .CYC_LEN  (CYC_LEN),
      .T_W_ON   (T_W_ON),
      .T_B_ON   (T_B_ON),
      .T_A_ON   (T_A_ON),
      .T_CUR_ON (T_CUR_ON),
      .T_PH1    (T_PH1),
      .T_PH2    (T_PH2),
      .T_PH_END (T_PH_END),
      .T_REL    (T_REL),
      .T_STRB   (T_STRB),
      .STRB_LEN (STRB_LEN),
      .T_VALID  (T_VALID),
      .T_CUR_OFF(T_CUR_OFF),
      .T_SEL_OFF(T_SEL_OFF)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (load),
      .rd_i    (cyc_rd),
      .active_o(active),
      .ph_o    (ph)
   );

   wsel_onehot_dec #(.IDX_W(W_BITS)) u_w_dec (
      .en_i(ph.w_win), .idx_i(w_idx), .oh_o(w_sel_o)
   );
   wsel_onehot_dec #(.IDX_W(BH_BITS)) u_bb_dec (
      .en_i(ph.b_win), .idx_i(bb_idx), .oh_o(b_base_o)
   );
   wsel_onehot_dec #(.IDX_W(BH_BITS)) u_be_dec (
      .en_i(ph.b_win), .idx_i(be_idx), .oh_o(b_emit_o)
   );
   wsel_onehot_dec #(.IDX_W(A_BITS)) u_a_dec (
      .en_i(ph.a_win), .idx_i(a_idx), .oh_o(a_sel_o)
   );

   assign ready_o     = !active;
   assign word_gate_o = ph.cur_win;
   assign sink_en_o   = !ph.cur_win;
   assign rest_hold_o = !ph.rel_win;
   assign strobe_o    = ph.strb;
   assign rd_valid_o  = ph.valid;
   assign wph1_o      = ph.ph1;
   assign wph2_o      = ph.ph2;
endmodule

// File: rtl/wsel_chk.sv
module wsel_chk #(
   parameter int unsigned W_N  = 16,
   parameter int unsigned BH_N = 8,
   parameter int unsigned A_N  = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ready_o,
   input logic            rd_valid_o,
   input logic [W_N-1:0]  w_sel_o,
   input logic [BH_N-1:0] b_base_o,
   input logic [BH_N-1:0] b_emit_o,
   input logic [A_N-1:0]  a_sel_o,
   input logic            sink_en_o,
   input logic            word_gate_o,
   input logic            rest_hold_o,
   input logic            strobe_o,
   input logic            wph1_o,
   input logic            wph2_o
);
   AST_W_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(w_sel_o)); // R2
   AST_B_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(b_base_o) && $onehot0(b_emit_o) && ((|b_base_o) == (|b_emit_o))); // R3
   AST_A_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(a_sel_o)); // R4
   AST_A_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (|a_sel_o) && $past(|a_sel_o) |-> $stable(a_sel_o)); // R4
   AST_GATE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      word_gate_o |-> (|w_sel_o) && (|b_base_o) && (|a_sel_o) && !sink_en_o); // R5
   AST_B_AFTER_W: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|b_base_o) |-> (|w_sel_o)); // R6
   AST_A_AFTER_B: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|a_sel_o) |-> (|b_base_o)); // R6
   AST_SINK_AFTER_A: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sink_en_o) |-> (|a_sel_o)); // R6
   AST_STROBE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> !rest_hold_o && word_gate_o && !wph1_o && !wph2_o); // R7
   AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> $past(strobe_o)); // R7
   AST_PHASES_IN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (wph1_o || wph2_o) |-> word_gate_o && rest_hold_o && !(wph1_o && wph2_o)); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> sink_en_o && !word_gate_o && (w_sel_o == '0) && (a_sel_o == '0)
                  && (b_base_o == '0) && !strobe_o); // R9
endmodule

bind wsel_cycle_seq wsel_chk #(.W_N(W_N), .BH_N(BH_N), .A_N(A_N)) u_wsel_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ready_o    (ready_o),
   .rd_valid_o (rd_valid_o),
   .w_sel_o    (w_sel_o),
   .b_base_o   (b_base_o),
   .b_emit_o   (b_emit_o),
   .a_sel_o    (a_sel_o),
   .sink_en_o  (sink_en_o),
   .word_gate_o(word_gate_o),
   .rest_hold_o(rest_hold_o),
   .strobe_o   (strobe_o),
   .wph1_o     (wph1_o),
   .wph2_o     (wph2_o)
);

// File: tb/wsel_cycle_seq_tb_top.sv
module wsel_cycle_seq_tb_top;
   localparam int CYC = 50;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic        wr_i = 1'b0;
   logic [13:0] addr_i = '0;
   logic        ready_o, rd_valid_o, sink_en_o, word_gate_o, rest_hold_o;
   logic        strobe_o, wph1_o, wph2_o;
   logic [15:0] w_sel_o, a_sel_o;
   logic [7:0]  b_base_o, b_emit_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   logic [14:0] exp_q[$];   // {rd, addr}

   always #2 clk = ~clk;    // 250 MHz

   wsel_cycle_seq dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
      .ready_o(ready_o), .rd_valid_o(rd_valid_o), .w_sel_o(w_sel_o),
      .b_base_o(b_base_o), .b_emit_o(b_emit_o), .a_sel_o(a_sel_o),
      .sink_en_o(sink_en_o), .word_gate_o(word_gate_o), .rest_hold_o(rest_hold_o),
      .strobe_o(strobe_o), .wph1_o(wph1_o), .wph2_o(wph2_o)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Timing vector: ready,w,b,a,gate,sink,hold,strobe,valid,ph1,ph2
   function automatic logic [10:0] act_vec();
      return {ready_o, |w_sel_o, |b_base_o, |a_sel_o, word_gate_o, sink_en_o,
              rest_hold_o, strobe_o, rd_valid_o, wph1_o, wph2_o};
   endfunction

   function automatic logic [10:0] exp_vec(input bit rd, input int k);
      logic gate;
      gate = (k >= 12 && k < 40);
      return {1'b0, (k >= 2 && k < 44), (k >= 6 && k < 44), (k >= 10 && k < 44), gate, !gate,
              !(rd && k >= 26 && k < 30), rd && (k >= 28 && k < 30), rd && (k == 30),
              !rd && (k >= 14 && k < 22), !rd && (k >= 22 && k < 30)};
   endfunction

   task automatic check_idle(input string req);
      check(act_vec() == 11'b10000110000 && w_sel_o == '0 && a_sel_o == '0
            && b_base_o == '0 && b_emit_o == '0, req, act_vec(), 11'b10000110000);
   endtask

   // Driver: one cycle, optional busy-time intrusion
   task automatic do_cycle(input bit rd, input logic [13:0] addr, input bit intrude);
      @(negedge clk);
      req_i = 1'b1; wr_i = !rd; addr_i = addr;
      exp_q.push_back({rd, addr});
      @(negedge clk);
      req_i = 1'b0; addr_i = '0;
      for (int k = 0; k < CYC; k++) begin
         // R2 R3 R4 R5 R6 R7 R8 timing vector per count
         check(act_vec() == exp_vec(rd, k), rd ? "R7 read timing" : "R8 write timing",
               act_vec(), exp_vec(rd, k));
         if (intrude && k == 20) begin
            req_i = 1'b1; wr_i = rd; addr_i = ~addr;   // R10 busy request
         end
         if (intrude && k == 47) req_i = 1'b0;
         if (k < CYC - 1) @(negedge clk);
      end
      @(negedge clk);
      check_idle("R9 end of cycle");
      if (intrude) begin
         @(negedge clk);
         check_idle("R10 busy request not taken");
      end
   endtask

   // Monitor: compare selects at the data-valid pulse or write true phase start
   logic ph2_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n && (rd_valid_o || (wph2_o && !ph2_prev))) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected cycle", 0, 0);
         end else begin
            logic [14:0] e;
            logic [45:0] a_v, e_v;
            e = exp_q.pop_front();
            a_v = {rd_valid_o, w_sel_o, b_emit_o, b_base_o, a_sel_o[12:0]};
            e_v = {e[14], 16'(1) << e[3:0], 8'(1) << e[9:7], 8'(1) << e[6:4],
                   13'((16'(1) << e[13:10]))};
            check(a_v == e_v && a_sel_o == 16'(1) << e[13:10],
                  "R3 R4 select decode", {a_sel_o, a_v[45:13]}, e_v);
         end
      end
      ph2_prev <= wph2_o;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check_idle("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1 after reset");
      do_cycle(1'b1, 14'h0000, 1'b0);
      do_cycle(1'b0, 14'h0000, 1'b0);
      do_cycle(1'b1, 14'h3FFF, 1'b0);
      do_cycle(1'b0, 14'h3FFF, 1'b0);
      do_cycle(1'b1, 14'h2AAA, 1'b0);
      do_cycle(1'b0, 14'h1555, 1'b0);
      do_cycle(1'b1, 14'h0070, 1'b0);   // base half only
      do_cycle(1'b1, 14'h0380, 1'b0);   // emitter half only
      do_cycle(1'b0, 14'h000F, 1'b0);   // wire only
      do_cycle(1'b1, 14'h3C00, 1'b0);   // line only
      do_cycle(1'b1, 14'h1234, 1'b1);   // R10 intrusion during read
      do_cycle(1'b0, 14'h2DCB, 1'b1);   // R10 intrusion during write
      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R2 every cycle observed", exp_q.size(), 0);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule